// File: doc/BRIEF.md
# Multi-latency execute writeback pipeline

This block models the execute phases of a statically scheduled processor core. One instruction may be presented on the issue port in every cycle. Each carries a kind code, a predicate result, a destination register index, two operand values, an immediate and an arithmetic function code. The issue cycle is execute phase one (E1). From there each kind finishes on its own fixed schedule: a register write, a memory request, or a fetch redirect, each in the phase its kind dictates. No interlocks exist: the scheduler that feeds the block must account for every delay slot itself.

Register results leave through three write lanes that a register file applies in parallel. Lane 0 carries results due in E1, lane 1 results due in E2 and lane 2 results due in E5. So a result finishing in a given cycle is never held back by a multiply that is still in its delay slot. When two lanes target the same register in one cycle, the younger instruction (the lower lane) wins. The older write is dropped and a conflict flag is raised. Loads and stores use a single memory request port. The memory answers a read with a fixed timing, so no handshake is needed. A redirect strobe, its target and a countdown of the delay slots left for the newest branch in flight let a fetch unit or a test environment line up redirect timing with the issue cycle.

Top module: `exec_pipe_top`

## Requirements
- R1: An issued kind-1 (arithmetic) instruction with a true predicate asserts lane 0 (wrEn[0]) in its issue cycle, with its destination index. The data is opA+opB for function 0, opA-opB for function 1, and opA for functions 2 and 3.
- R2: A kind-2 (multiply) instruction with a true predicate writes the low 32 bits of opA*opB on lane 1 exactly one cycle after issue, which gives one delay slot.
- R3: A kind-3 (load) instruction with a true predicate raises memReq with memWe low and memAddr = opA+imm one cycle after issue. The memory supplies the data on memRdata during the third cycle after issue. That data is written on lane 2 four cycles after issue.
- R4: A kind-4 (store) instruction with a true predicate raises memReq with memWe high, memAddr = opA+imm and memWdata = opB one cycle after issue. It never asserts any write lane.
- R5: A kind-5 (branch) instruction with a true predicate pulses redirect exactly five cycles after issue, with redirectTarget equal to its immediate.
- R6: branchSlotsLeft equals 5 minus the cycles elapsed since issue for the newest live branch issued one to five cycles earlier, and 0 when there is none.
- R7: An instruction whose predicate is false produces no lane write, no memory request and no redirect, in E1 or any later cycle.
- R8: Kind codes 0, 6 and 7 (no-operation), and cycles with issueValid low, produce no activity at all.
- R9: If several lanes target the same register in one cycle, only the lowest-numbered of them stays enabled, and wrConflict is high in that cycle. Otherwise wrConflict is low.
- R10: Instructions may issue in consecutive cycles with no stall. Results from different lanes that are due in the same cycle all appear in that cycle.
- R11: A synchronous active-high reset discards every instruction in flight. After it, no lane write, memory request or redirect appears until new instructions are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueValid | input | 1 | An instruction is presented this cycle |
| issueOp | input | 3 | Kind: 0 none, 1 arithmetic, 2 multiply, 3 load, 4 store, 5 branch, 6/7 none |
| issueAluFn | input | 2 | Arithmetic function: 0 add, 1 subtract, 2/3 move opA |
| issuePred | input | 1 | Predicate outcome; low cancels the instruction |
| issueDst | input | 4 | Destination register index |
| issueOpA | input | 32 | First operand / base address |
| issueOpB | input | 32 | Second operand / store data |
| issueImm | input | 32 | Address offset / branch target |
| wrEn | output | 3 | Per-lane write enable (lane 0 = E1, 1 = E2, 2 = E5) |
| wrAddr | output | 12 | Lane destinations, lane i at bits [4i+3:4i] |
| wrData | output | 96 | Lane data, lane i at bits [32i+31:32i] |
| wrConflict | output | 1 | Same-register collision between lanes this cycle |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Request address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid in the third cycle after load issue |
| redirect | output | 1 | Fetch redirect strobe |
| redirectTarget | output | 32 | Redirect destination |
| branchSlotsLeft | output | 3 | Delay slots remaining for the newest branch in flight |

## Verification
On every cycle the assertions check the fixed per-kind timing. An arithmetic result is on lane 0 in its issue cycle, and a multiply or load result reaches its lane (or loses a reported collision) one or four cycles later. A store becomes a write request one cycle after issue, and a redirect appears exactly five cycles after its branch. They also check that every memory request traces back to a live instruction, that the pipe is empty right after reset, and that the countdown stays in range. The data values, the subtraction and move variants, the address and target arithmetic, and the round trip of load data through the memory model are visible only through the bench's scenarios against its reference model. So are which lane survives a collision, the countdown when branches overlap, and the discarding of work in flight by a reset.

// File: rtl/exec_pkg.sv
package exec_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ALU    = 3'd1,
    OP_MUL    = 3'd2,
    OP_LOAD   = 3'd3,
    OP_STORE  = 3'd4,
    OP_BRANCH = 3'd5
  } opKind_e;

  // execute phase numbering: issue cycle is phase 1
  localparam int MEM_STAGE      = 2;
  localparam int MUL_WB_STAGE   = 2;
  localparam int LOAD_CAP_STAGE = 4;
  localparam int LOAD_WB_STAGE  = 5;
  localparam int REDIRECT_STAGE = 6;
  localparam int STAGE_LAST     = REDIRECT_STAGE;
  localparam int SLOT_W         = $clog2(STAGE_LAST - 1);

  // write lanes ordered youngest producer first (lower lane wins)
  localparam int LANE_E1   = 0;
  localparam int LANE_E2   = 1;
  localparam int LANE_E5   = 2;
  localparam int NUM_LANES = 3;

  typedef struct packed {
    logic mulCap;
    logic memCap;
    logic ldCap;
    logic brCap;
  } dpStrobe_t;

  function automatic int lastStage(opKind_e op);
    case (op)
      OP_MUL, OP_STORE: return MEM_STAGE;
      OP_LOAD:          return LOAD_WB_STAGE;
      OP_BRANCH:        return REDIRECT_STAGE;
      default:          return 1;
    endcase
  endfunction

endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         issueValid,
  input  logic [2:0]                   issueOp,
  input  logic                         issuePred,
  input  logic [IDX_W-1:0]             issueDst,
  output dpStrobe_t                    strobe,
  output logic [NUM_LANES-1:0]         wrEn,
  output logic [NUM_LANES*IDX_W-1:0]   wrAddr,
  output logic                         wrConflict,
  output logic                         memReq,
  output logic                         memWe,
  output logic                         redirect,
  output logic [SLOT_W-1:0]            slotsLeft
);

  typedef struct packed {
    logic             live;
    opKind_e          op;
    logic [IDX_W-1:0] dst;
  } stage_t;

  opKind_e issueKind;
  logic    issueLive;
  stage_t  entry;
  stage_t  stg [2:STAGE_LAST];

  assign issueKind = opKind_e'(issueOp);
  assign issueLive = issueValid && issuePred;

  always_comb begin
    entry      = '0;
    entry.live = issueLive && (lastStage(issueKind) >= 2);
    entry.op   = issueKind;
    entry.dst  = issueDst;
  end

  always_ff @(posedge clk) begin
    if (rst) stg[2] <= '0;
    else     stg[2] <= entry;
  end

  for (genvar k = 3; k <= STAGE_LAST; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg[k] <= '0;
      end else begin
        stg[k]      <= stg[k-1];
        stg[k].live <= stg[k-1].live && (lastStage(stg[k-1].op) >= k);
      end
    end
  end

  // raw lane requests, youngest producer on the lowest lane
  logic [NUM_LANES-1:0] rawEn;
  logic [IDX_W-1:0]     rawDst [NUM_LANES];
  logic [NUM_LANES-1:0] lost;

  assign rawEn[LANE_E1]  = issueLive && (issueKind == OP_ALU);
  assign rawDst[LANE_E1] = issueDst;
  assign rawEn[LANE_E2]  = stg[MUL_WB_STAGE].live && (stg[MUL_WB_STAGE].op == OP_MUL);
  assign rawDst[LANE_E2] = stg[MUL_WB_STAGE].dst;
  assign rawEn[LANE_E5]  = stg[LOAD_WB_STAGE].live && (stg[LOAD_WB_STAGE].op == OP_LOAD);
  assign rawDst[LANE_E5] = stg[LOAD_WB_STAGE].dst;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic beaten;
    always_comb begin
      beaten = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (rawEn[j] && (rawDst[j] == rawDst[i])) beaten = 1'b1;
      end
    end
    assign wrEn[i]                  = rawEn[i] && !beaten;
    assign lost[i]                  = rawEn[i] && beaten;
    assign wrAddr[i*IDX_W +: IDX_W] = rawDst[i];
  end

  assign wrConflict = |lost;

  assign strobe.mulCap = issueLive && (issueKind == OP_MUL);
  assign strobe.memCap = issueLive && ((issueKind == OP_LOAD) || (issueKind == OP_STORE));
  assign strobe.ldCap  = stg[LOAD_CAP_STAGE].live && (stg[LOAD_CAP_STAGE].op == OP_LOAD);
  assign strobe.brCap  = issueLive && (issueKind == OP_BRANCH);

  assign memReq   = stg[MEM_STAGE].live &&
                    ((stg[MEM_STAGE].op == OP_LOAD) || (stg[MEM_STAGE].op == OP_STORE));
  assign memWe    = stg[MEM_STAGE].live && (stg[MEM_STAGE].op == OP_STORE);
  assign redirect = stg[REDIRECT_STAGE].live && (stg[REDIRECT_STAGE].op == OP_BRANCH);

  // newest branch sits in the lowest stage; scan oldest to newest
  always_comb begin
    slotsLeft = '0;
    for (int k = STAGE_LAST; k >= 2; k--) begin
      if (stg[k].live && (stg[k].op == OP_BRANCH)) slotsLeft = SLOT_W'(STAGE_LAST - k);
    end
  end

endmodule

// File: rtl/exec_dp.sv
module exec_dp
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  dpStrobe_t                     strobe,
  input  logic [1:0]                    issueAluFn,
  input  logic [DATA_W-1:0]             issueOpA,
  input  logic [DATA_W-1:0]             issueOpB,
  input  logic [DATA_W-1:0]             issueImm,
  input  logic [DATA_W-1:0]             memRdata,
  output logic [NUM_LANES*DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]             memAddr,
  output logic [DATA_W-1:0]             memWdata,
  output logic [DATA_W-1:0]             redirectTarget
);

  logic [DATA_W-1:0] aluRes;
  logic [DATA_W-1:0] mulQ;
  logic [DATA_W-1:0] ldQ;
  logic [DATA_W-1:0] tgt [2:STAGE_LAST];

  always_comb begin
    case (issueAluFn)
      2'd0:    aluRes = issueOpA + issueOpB;
      2'd1:    aluRes = issueOpA - issueOpB;
      default: aluRes = issueOpA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.mulCap) mulQ <= issueOpA * issueOpB;
    if (strobe.memCap) begin
      memAddr  <= issueOpA + issueImm;
      memWdata <= issueOpB;
    end
    if (strobe.ldCap) ldQ <= memRdata;
    if (strobe.brCap) tgt[2] <= issueImm;
  end

  for (genvar k = 3; k <= STAGE_LAST; k++) begin : g_tgt
    always_ff @(posedge clk) tgt[k] <= tgt[k-1];
  end

  assign wrData[LANE_E1*DATA_W +: DATA_W] = aluRes;
  assign wrData[LANE_E2*DATA_W +: DATA_W] = mulQ;
  assign wrData[LANE_E5*DATA_W +: DATA_W] = ldQ;
  assign redirectTarget = tgt[REDIRECT_STAGE];

endmodule

// File: rtl/exec_pipe_top.sv
module exec_pipe_top
  import exec_pkg::*;
#(
  parameter  int DATA_W    = 32,
  parameter  int REG_COUNT = 16,
  localparam int IDX_W     = $clog2(REG_COUNT)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        issueValid,
  input  logic [2:0]                  issueOp,
  input  logic [1:0]                  issueAluFn,
  input  logic                        issuePred,
  input  logic [IDX_W-1:0]            issueDst,
  input  logic [DATA_W-1:0]           issueOpA,
  input  logic [DATA_W-1:0]           issueOpB,
  input  logic [DATA_W-1:0]           issueImm,
  output logic [NUM_LANES-1:0]        wrEn,
  output logic [NUM_LANES*IDX_W-1:0]  wrAddr,
  output logic [NUM_LANES*DATA_W-1:0] wrData,
  output logic                        wrConflict,
  output logic                        memReq,
  output logic                        memWe,
  output logic [DATA_W-1:0]           memAddr,
  output logic [DATA_W-1:0]           memWdata,
  input  logic [DATA_W-1:0]           memRdata,
  output logic                        redirect,
  output logic [DATA_W-1:0]           redirectTarget,
  output logic [SLOT_W-1:0]           branchSlotsLeft
);

  dpStrobe_t strobe;

  exec_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .issueValid (issueValid),
    .issueOp    (issueOp),
    .issuePred  (issuePred),
    .issueDst   (issueDst),
    .strobe     (strobe),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrConflict (wrConflict),
    .memReq     (memReq),
    .memWe      (memWe),
    .redirect   (redirect),
    .slotsLeft  (branchSlotsLeft)
  );

  exec_dp #(.DATA_W(DATA_W)) u_dp (
    .clk            (clk),
    .strobe         (strobe),
    .issueAluFn     (issueAluFn),
    .issueOpA       (issueOpA),
    .issueOpB       (issueOpB),
    .issueImm       (issueImm),
    .memRdata       (memRdata),
    .wrData         (wrData),
    .memAddr        (memAddr),
    .memWdata       (memWdata),
    .redirectTarget (redirectTarget)
  );

endmodule

// File: rtl/exec_pipe_chk.sv
module exec_pipe_chk
  import exec_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       issueValid,
  input logic [2:0]                 issueOp,
  input logic                       issuePred,
  input logic [IDX_W-1:0]           issueDst,
  input logic [NUM_LANES-1:0]       wrEn,
  input logic [NUM_LANES*IDX_W-1:0] wrAddr,
  input logic                       wrConflict,
  input logic                       memReq,
  input logic                       memWe,
  input logic                       redirect,
  input logic [SLOT_W-1:0]          branchSlotsLeft
);

  // cycles since reset, saturating, bounds every look into the past
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  logic liveIssue;
  assign liveIssue = issueValid && issuePred;

  assert_alu_e1_write_R1: assert property (@(posedge clk) disable iff (rst)
    (liveIssue && issueOp == 3'd1) |-> (wrEn[LANE_E1] && wrAddr[IDX_W-1:0] == issueDst));

  assert_mul_one_slot_R2: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && $past(liveIssue && issueOp == 3'd2))
      |-> (wrEn[LANE_E2] || (wrEn[LANE_E1] && wrConflict)));

  assert_load_four_slots_R3: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && $past(liveIssue && issueOp == 3'd3, 4))
      |-> (wrEn[LANE_E5] || wrConflict));

  assert_store_request_R4: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && $past(liveIssue && issueOp == 3'd4)) |-> (memReq && memWe));

  assert_branch_redirect_R5: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5 && $past(liveIssue && issueOp == 3'd5, 5)) |-> redirect);

  assert_redirect_has_source_R5: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (age >= 3'd5));

  assert_slots_range_R6: assert property (@(posedge clk) disable iff (rst)
    branchSlotsLeft <= SLOT_W'(STAGE_LAST - 2));

  assert_mem_needs_live_issue_R7: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && memReq) |-> $past(liveIssue));

  assert_conflict_has_winner_R9: assert property (@(posedge clk) disable iff (rst)
    wrConflict |-> ($countones(wrEn) >= 1));

  assert_empty_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    (age == 3'd0) |-> (!memReq && !redirect && wrEn[LANE_E5:LANE_E2] == '0));

endmodule

bind exec_pipe_top exec_pipe_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_exec_pipe_top.sv
module tb_exec_pipe_top;

  localparam int DW = 32;
  localparam int IW = 4;
  localparam int RING = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          issueValid = 1'b0;
  logic [2:0]    issueOp = '0;
  logic [1:0]    issueAluFn = '0;
  logic          issuePred = 1'b0;
  logic [IW-1:0] issueDst = '0;
  logic [DW-1:0] issueOpA = '0, issueOpB = '0, issueImm = '0;
  logic [2:0]    wrEn;
  logic [3*IW-1:0] wrAddr;
  logic [3*DW-1:0] wrData;
  logic          wrConflict, memReq, memWe, redirect;
  logic [DW-1:0] memAddr, memWdata, memRdata, redirectTarget;
  logic [2:0]    branchSlotsLeft;

  always #2 clk = ~clk;

  exec_pipe_top dut (.*);

  // memory model: read data is back during the third cycle after issue
  function automatic logic [31:0] memHash(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  logic [DW-1:0] memP1 = '0, memP2 = '0;
  initial memRdata = '0;
  always @(negedge clk) begin
    memRdata <= memP2;
    memP2    <= memP1;
    memP1    <= (memReq === 1'b1 && memWe === 1'b0) ? memHash(memAddr) : 32'hDEAD_BEEF;
  end

  // reference model: per-cycle expectation ring
  bit          expEn   [RING][3];
  logic [3:0]  expAddr [RING][3];
  logic [31:0] expData [RING][3];
  bit          expMem  [RING];
  bit          expWe   [RING];
  logic [31:0] expMA   [RING];
  logic [31:0] expMD   [RING];
  bit          expRd   [RING];
  logic [31:0] expTgt  [RING];
  int          brIssue [$];
  int          cur = 0;
  int          nChecks = 0;
  int          nFail = 0;
  string       scen = "reset";

  task automatic cmp(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s [%s] cycle %0d %s: got %h expected %h", req, scen, cur, what, got, exp);
    end
  endtask

  task automatic clearSlot(input int s);
    for (int i = 0; i < 3; i++) expEn[s][i] = 1'b0;
    expMem[s] = 1'b0; expWe[s] = 1'b0; expRd[s] = 1'b0;
  endtask

  task automatic checkNow();
    int s = cur % RING;
    bit eff [3];
    bit conf = 1'b0;
    int newest = -1;
    int slots = 0;
    for (int i = 0; i < 3; i++) begin
      eff[i] = expEn[s][i];
      for (int j = 0; j < i; j++)
        if (expEn[s][j] && expEn[s][i] && expAddr[s][j] == expAddr[s][i]) eff[i] = 1'b0;
      if (expEn[s][i] && !eff[i]) conf = 1'b1;
    end
    for (int i = 0; i < 3; i++) begin
      string rq = (i == 0) ? "R1" : (i == 1) ? "R2" : "R3";
      cmp(rq, $sformatf("lane%0d enable", i), {31'd0, wrEn[i]}, {31'd0, eff[i]});
      if (eff[i]) begin
        cmp(rq, $sformatf("lane%0d addr", i), {28'd0, wrAddr[i*IW +: IW]}, {28'd0, expAddr[s][i]});
        cmp(rq, $sformatf("lane%0d data", i), wrData[i*DW +: DW], expData[s][i]);
      end
    end
    cmp("R9", "conflict flag", {31'd0, wrConflict}, {31'd0, conf});
    cmp(expWe[s] ? "R4" : "R3", "memReq", {31'd0, memReq}, {31'd0, expMem[s]});
    if (expMem[s]) begin
      cmp("R4", "memWe", {31'd0, memWe}, {31'd0, expWe[s]});
      cmp(expWe[s] ? "R4" : "R3", "memAddr", memAddr, expMA[s]);
      if (expWe[s]) cmp("R4", "memWdata", memWdata, expMD[s]);
    end
    cmp("R5", "redirect", {31'd0, redirect}, {31'd0, expRd[s]});
    if (expRd[s]) cmp("R5", "redirect target", redirectTarget, expTgt[s]);
    while (brIssue.size() > 0 && cur - brIssue[0] > 5) void'(brIssue.pop_front());
    foreach (brIssue[k]) if (cur - brIssue[k] >= 1 && brIssue[k] > newest) newest = brIssue[k];
    if (newest >= 0) slots = 5 - (cur - newest);
    cmp("R6", "slots left", {29'd0, branchSlotsLeft}, slots);
  endtask

  task automatic tick(input bit doCheck);
    #1;
    if (doCheck) checkNow();
    @(negedge clk);
    clearSlot(cur % RING);
    cur++;
  endtask

  task automatic issue(input bit v, input logic [2:0] op, input logic [1:0] fn, input bit p,
                       input logic [3:0] d, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] im);
    issueValid = v; issueOp = op; issueAluFn = fn; issuePred = p;
    issueDst = d; issueOpA = a; issueOpB = b; issueImm = im;
    if (v && p) begin
      case (op)
        3'd1: begin
          expEn[cur%RING][0] = 1'b1; expAddr[cur%RING][0] = d;
          expData[cur%RING][0] = (fn == 2'd0) ? a + b : (fn == 2'd1) ? a - b : a;
        end
        3'd2: begin
          expEn[(cur+1)%RING][1] = 1'b1; expAddr[(cur+1)%RING][1] = d;
          expData[(cur+1)%RING][1] = a * b;
        end
        3'd3: begin
          expMem[(cur+1)%RING] = 1'b1; expWe[(cur+1)%RING] = 1'b0; expMA[(cur+1)%RING] = a + im;
          expEn[(cur+4)%RING][2] = 1'b1; expAddr[(cur+4)%RING][2] = d;
          expData[(cur+4)%RING][2] = memHash(a + im);
        end
        3'd4: begin
          expMem[(cur+1)%RING] = 1'b1; expWe[(cur+1)%RING] = 1'b1;
          expMA[(cur+1)%RING] = a + im; expMD[(cur+1)%RING] = b;
        end
        3'd5: begin
          expRd[(cur+5)%RING] = 1'b1; expTgt[(cur+5)%RING] = im;
          brIssue.push_back(cur);
        end
        default: ;
      endcase
    end
    tick(1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, 3'd0, 2'd0, 1'b0, 4'd0, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic doReset(input int n);
    rst = 1'b1; issueValid = 1'b0;
    for (int i = 0; i < n; i++) tick(1'b0);
    for (int s = 0; s < RING; s++) clearSlot(s);
    brIssue.delete();
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    doReset(3);
    scen = "R11 state after reset";
    idle(3);

    scen = "R1 arithmetic variants";
    issue(1, 3'd1, 2'd0, 1, 4'd1, 32'd100, 32'd23, 0);
    issue(1, 3'd1, 2'd1, 1, 4'd2, 32'd5, 32'd9, 0);
    issue(1, 3'd1, 2'd2, 1, 4'd3, 32'hCAFE_0001, 32'd7, 0);
    issue(1, 3'd1, 2'd3, 1, 4'd4, 32'h1234_5678, 32'd7, 0);
    idle(2);

    scen = "R2 R10 multiply then arithmetic in its delay slot";
    issue(1, 3'd2, 2'd0, 1, 4'd5, 32'h0001_0003, 32'h0002_0005, 0);
    issue(1, 3'd1, 2'd0, 1, 4'd6, 32'd1, 32'd2, 0);
    issue(1, 3'd2, 2'd0, 1, 4'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    idle(2);

    scen = "R3 R4 load and store";
    issue(1, 3'd3, 2'd0, 1, 4'd8, 32'h1000, 32'd0, 32'h24);
    issue(1, 3'd4, 2'd0, 1, 4'd9, 32'h2000, 32'hBEEF_0042, 32'h8);
    issue(1, 3'd3, 2'd0, 1, 4'd10, 32'h3000, 32'd0, 32'h4);
    idle(6);

    scen = "R5 R6 overlapping branches";
    issue(1, 3'd5, 2'd0, 1, 4'd0, 0, 0, 32'h0000_4000);
    idle(1);
    issue(1, 3'd5, 2'd0, 1, 4'd0, 0, 0, 32'h0000_8800);
    idle(7);

    scen = "R7 false predicate on every kind";
    for (int op = 1; op <= 5; op++) issue(1, 3'(op), 2'd0, 0, 4'd11, 32'd3, 32'd4, 32'h50);
    idle(6);

    scen = "R8 no-operation codes";
    issue(1, 3'd0, 2'd0, 1, 4'd12, 32'd1, 32'd1, 32'd1);
    issue(1, 3'd6, 2'd0, 1, 4'd12, 32'd1, 32'd1, 32'd1);
    issue(1, 3'd7, 2'd0, 1, 4'd12, 32'd1, 32'd1, 32'd1);
    idle(6);

    scen = "R9 three-way collision";
    issue(1, 3'd3, 2'd0, 1, 4'd5, 32'h40, 0, 32'h4);
    idle(2);
    issue(1, 3'd2, 2'd0, 1, 4'd5, 32'd6, 32'd7, 0);
    issue(1, 3'd1, 2'd0, 1, 4'd5, 32'd10, 32'd20, 0);
    scen = "R9 load versus multiply";
    issue(1, 3'd3, 2'd0, 1, 4'd2, 32'h80, 0, 32'h0);
    idle(2);
    issue(1, 3'd2, 2'd0, 1, 4'd2, 32'd3, 32'd3, 0);
    issue(1, 3'd1, 2'd0, 1, 4'd9, 32'd1, 32'd1, 0);
    idle(5);

    scen = "R11 reset with work in flight";
    issue(1, 3'd3, 2'd0, 1, 4'd1, 32'h100, 0, 0);
    issue(1, 3'd5, 2'd0, 1, 4'd0, 0, 0, 32'h7777);
    issue(1, 3'd2, 2'd0, 1, 4'd3, 32'd2, 32'd2, 0);
    doReset(1);
    idle(7);

    scen = "R10 random back-to-back stream";
    for (int n = 0; n < 600; n++)
      issue(($urandom % 8) != 0, 3'($urandom % 8), 2'($urandom % 4), ($urandom % 4) != 0,
            4'($urandom % 4), $urandom, $urandom, $urandom);
    idle(8);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog [%s] cycle %0d: got timeout expected completion", scen, cur);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule